// File: doc/BRIEF.md
# Half-Step Stepper Motor Sequencer

This block drives the four coil phases of a geared unipolar stepper motor through an external darlington driver array. It holds a signed count of half-steps still to be taken. On every tick of an internal fixed-rate tick generator it takes one half-step through an eight-state phase pattern. A positive count walks the pattern forward and a negative count walks it backward.

Two active-low pushbuttons start moves. Each button has pull-ups and requests half a turn of the output shaft in its own direction. Both buttons are synchronised and debounced. A press is acted on only when the motor is standing still.

Three indicator outputs show the motion state:
- green means idle,
- red means the motor is turning forward,
- blue means the motor is turning backward.

Top module: `halfstep_sequencer`

## Requirements
- R1: `phase` only ever takes the value 0000 or a state of the eight-state pattern. The pattern, by index 0 to 7, is 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001. Bit 0 drives coil A. On each half-step `phase` takes the pattern value of the new index.
- R2: While the pending count is positive, each tick moves the index one place up, wrapping from 7 to 0, and lowers the count by one.
- R3: While the pending count is negative, each tick moves the index one place down, wrapping from 0 to 7, and raises the count by one.
- R4: While the pending count is zero, `phase` keeps its last value and `led_green` is 1.
- R5: Exactly one indicator is lit at all times: `led_red` while the count is positive, `led_blue` while it is negative, `led_green` while it is zero.
- R6: Ticks occur every TICK_PERIOD = CLK_HZ/STEP_HZ clock cycles, counted from reset release. The first tick is on rising edge number TICK_PERIOD. The default step rate is 800 per second.
- R7: One shaft revolution is REV_STEPS = 4076 half-steps. An accepted forward press loads +2038 and an accepted backward press loads -2038, so a move from index i ends at index (i ± 2038) mod 8.
- R8: A request is made only by the falling (press) edge of a debounced button. It is accepted only while the pending count is zero. Presses during motion and all releases have no effect.
- R9: Each button passes through two synchronising flops and then a debouncer that needs the new level to hold for DEBOUNCE_MS of clock cycles, which is 10 ms by default. A press held low changes the pending count on rising edge DEB+3 after it is applied. A low pulse shorter than DEB cycles is ignored.
- R10: If both debounced buttons fall in the same cycle while the motor is idle, the forward request wins and the backward one is dropped.
- R11: After reset the index is 0, the pending count is 0, `phase` is 0000 and only `led_green` is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_fwd_n | input | 1 | Forward half-turn button, active low |
| btn_rev_n | input | 1 | Backward half-turn button, active low |
| phase | output | 4 | Coil drive, bit 0 = coil A |
| led_red | output | 1 | Moving forward |
| led_green | output | 1 | Idle |
| led_blue | output | 1 | Moving backward |

## Verification
The sequencer is driven with four button patterns:
- A glitch shorter than the debounce window. It must change nothing, which separates a working debouncer from a plain edge detector.
- A full forward move with a backward press and a release during it. Over 2038 steps this exercises many forward wraps of the index, and it shows that requests arriving during motion are dropped.
- A full backward move starting from index 6. This exercises the backward wrap and the blue indicator, and it must end exactly at index 0.
- Both buttons pressed together. This shows the forward priority.

Separate measurements cover three timing points:
- the exact edge on which a press takes effect,
- the spacing between steps,
- the holding of `phase` once the motor is idle.

// File: rtl/halfstep_pkg.sv
package halfstep_pkg;

  localparam int IDX_W = 3;

  // Pattern value for a given index: even indices drive a single coil,
  // odd indices drive the coil pair around them.
  function automatic logic [3:0] coil_pattern(input logic [IDX_W-1:0] idx);
    logic [3:0] pat;
    logic [1:0] lo;
    lo = idx[2:1];
    pat = 4'b0001 << lo;
    if (idx[0]) pat = pat | (4'b0001 << (lo + 2'd1));
    return pat;
  endfunction

  // Next index in the requested direction; 3-bit arithmetic wraps.
  function automatic logic [IDX_W-1:0] idx_advance(input logic [IDX_W-1:0] idx,
                                                   input logic fwd);
    return fwd ? idx + 3'd1 : idx - 3'd1;
  endfunction

endpackage

// File: rtl/hs_button_cond.sv
module hs_button_cond #(
  parameter int DEB_CYC = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic fall
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC + 1) : 1;

  logic          sync1_q, sync2_q, level_q, fall_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      level_q <= 1'b1;
      run_q   <= '0;
      fall_q  <= 1'b0;
    end else begin
      sync1_q <= btn_n;
      sync2_q <= sync1_q;
      fall_q  <= 1'b0;
      if (sync2_q == level_q) begin
        run_q <= '0;
      end else if (run_q == CW'(DEB_CYC - 1)) begin
        level_q <= sync2_q;
        run_q   <= '0;
        fall_q  <= ~sync2_q;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign fall = fall_q;
endmodule

// File: rtl/hs_tick_gen.sv
module hs_tick_gen #(
  parameter int TICK_PERIOD = 250_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;

  logic [TW-1:0] down_q;

  assign tick = (down_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    down_q <= TW'(TICK_PERIOD - 1);
    else if (tick) down_q <= TW'(TICK_PERIOD - 1);
    else           down_q <= down_q - 1'b1;
  end
endmodule

// File: rtl/hs_motion_core.sv
module hs_motion_core
  import halfstep_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int HALF_STEPS = 2038
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    req_fwd,
  input  logic                    req_rev,
  output logic [3:0]              phase,
  output logic signed [CNT_W-1:0] pend,
  output logic [IDX_W-1:0]        idx
);
  localparam logic signed [CNT_W-1:0] HALF_S = CNT_W'(HALF_STEPS);

  logic signed [CNT_W-1:0] pend_q;
  logic [IDX_W-1:0]        idx_q, idx_nxt;
  logic [3:0]              phase_q;
  logic                    dir_fwd;

  assign dir_fwd = ~pend_q[CNT_W-1];
  assign idx_nxt = idx_advance(idx_q, dir_fwd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      idx_q   <= '0;
      phase_q <= 4'b0000;
    end else if (pend_q != '0) begin
      if (tick) begin
        idx_q   <= idx_nxt;
        phase_q <= coil_pattern(idx_nxt);
        pend_q  <= dir_fwd ? pend_q - CNT_W'(1) : pend_q + CNT_W'(1);
      end
    end else if (req_fwd) begin
      pend_q <= HALF_S;
    end else if (req_rev) begin
      pend_q <= -HALF_S;
    end
  end

  assign phase = phase_q;
  assign pend  = pend_q;
  assign idx   = idx_q;
endmodule

// File: rtl/halfstep_sequencer.sv
module halfstep_sequencer
  import halfstep_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int STEP_HZ     = 800,
  parameter int DEBOUNCE_MS = 10,
  parameter int REV_STEPS   = 4076,
  parameter int CNT_W       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_fwd_n,
  input  logic       btn_rev_n,
  output logic [3:0] phase,
  output logic       led_red,
  output logic       led_green,
  output logic       led_blue
);
  localparam int TICK_PERIOD = CLK_HZ / STEP_HZ;
  localparam int DEB_CYC     = (CLK_HZ / 1000) * DEBOUNCE_MS;
  localparam int HALF_STEPS  = REV_STEPS / 2;
  localparam int N_BTN       = 2;

  logic [N_BTN-1:0]        btn_raw_n, fall_w;
  logic                    tick_w, fwd_fall_w, rev_fall_w;
  logic signed [CNT_W-1:0] pend_w;
  logic [IDX_W-1:0]        idx_w;

  assign btn_raw_n = {btn_rev_n, btn_fwd_n};

  for (genvar b = 0; b < N_BTN; b++) begin : g_btn
    hs_button_cond #(.DEB_CYC(DEB_CYC)) u_cond (
      .clk  (clk),
      .rst_n(rst_n),
      .btn_n(btn_raw_n[b]),
      .fall (fall_w[b])
    );
  end

  assign fwd_fall_w = fall_w[0];
  assign rev_fall_w = fall_w[1];

  hs_tick_gen #(.TICK_PERIOD(TICK_PERIOD)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w)
  );

  hs_motion_core #(.CNT_W(CNT_W), .HALF_STEPS(HALF_STEPS)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_w),
    .req_fwd(fwd_fall_w),
    .req_rev(rev_fall_w),
    .phase  (phase),
    .pend   (pend_w),
    .idx    (idx_w)
  );

  assign led_green = (pend_w == '0);
  assign led_blue  = pend_w[CNT_W-1];
  assign led_red   = ~pend_w[CNT_W-1] & (pend_w != '0);
endmodule

// File: rtl/hs_checker.sv
module hs_checker
  import halfstep_pkg::*;
#(
  parameter int TICK_PERIOD = 250_000,
  parameter int HALF_STEPS  = 2038,
  parameter int CNT_W       = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    fall_fwd,
  input logic                    fall_rev,
  input logic signed [CNT_W-1:0] pend,
  input logic [IDX_W-1:0]        idx,
  input logic [3:0]              phase,
  input logic                    led_red,
  input logic                    led_green,
  input logic                    led_blue
);
  localparam logic signed [CNT_W-1:0] HALF_S = CNT_W'(HALF_STEPS);

  logic [31:0] since_tick_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    since_tick_q <= '0;
    else if (tick) since_tick_q <= '0;
    else           since_tick_q <= since_tick_q + 1'b1;
  end

  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> since_tick_q == 32'(TICK_PERIOD - 1));

  assert_phase_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> $past(tick));

  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend > 0) |=> (idx == $past(idx) + 3'd1) && (pend == $past(pend) - 1));

  assert_rev_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend < 0) |=> (idx == $past(idx) - 3'd1) && (pend == $past(pend) + 1));

  assert_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> phase == coil_pattern(idx));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (led_green && $past(led_green)) |-> $stable(phase));

  assert_one_led_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({led_red, led_green, led_blue}));

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0 && !tick) |=> pend == $past(pend));

  assert_load_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && fall_fwd) |=> pend == HALF_S);

  assert_load_rev_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !fall_fwd && fall_rev) |=> pend == -HALF_S);
endmodule

bind halfstep_sequencer hs_checker #(
  .TICK_PERIOD(TICK_PERIOD),
  .HALF_STEPS (HALF_STEPS),
  .CNT_W      (CNT_W)
) u_hs_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_w),
  .fall_fwd (fwd_fall_w),
  .fall_rev (rev_fall_w),
  .pend     (pend_w),
  .idx      (idx_w),
  .phase    (phase),
  .led_red  (led_red),
  .led_green(led_green),
  .led_blue (led_blue)
);

// File: tb/halfstep_sequencer_test.sv
module halfstep_sequencer_test;
  localparam int CLK_HZ = 8000;
  localparam int STEP_HZ = 800;
  localparam int DEB_MS = 10;
  localparam int P = CLK_HZ / STEP_HZ;          // 10 cycles per step
  localparam int DEB = (CLK_HZ / 1000) * DEB_MS; // 80 cycles
  localparam int H = 2038;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_fwd_n = 1'b1;
  logic btn_rev_n = 1'b1;
  logic [3:0] phase;
  logic led_red, led_green, led_blue;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  halfstep_sequencer #(.CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ), .DEBOUNCE_MS(DEB_MS)) uut (
    .clk(clk), .rst_n(rst_n), .btn_fwd_n(btn_fwd_n), .btn_rev_n(btn_rev_n),
    .phase(phase), .led_red(led_red), .led_green(led_green), .led_blue(led_blue)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1 pattern restated as a lookup
  function automatic int ref_phase(input int i);
    case (i)
      0: return 4'b0001; 1: return 4'b0011; 2: return 4'b0010; 3: return 4'b0110;
      4: return 4'b0100; 5: return 4'b1100; 6: return 4'b1000; default: return 4'b1001;
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_edge, m_pend, m_idx, m_phase;
  int m_run[2];
  logic [1:0] m_stable, m_fall, synced, nf;
  logic [1:0] dq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edge = 0; m_pend = 0; m_idx = 0; m_phase = 0;
      m_run[0] = 0; m_run[1] = 0;
      m_stable = 2'b11; m_fall = 2'b00;
      dq = {2'b11, 2'b11};
    end else begin
      m_edge++;
      if (m_pend != 0) begin
        if (m_edge % P == 0) begin
          if (m_pend > 0) begin m_idx = (m_idx + 1) % 8; m_pend--; end
          else begin m_idx = (m_idx + 7) % 8; m_pend++; end
          m_phase = ref_phase(m_idx);
        end
      end else if (m_fall[0]) m_pend = H;
      else if (m_fall[1]) m_pend = -H;
      synced = dq[0];
      nf = 2'b00;
      for (int b = 0; b < 2; b++) begin
        if (synced[b] == m_stable[b]) m_run[b] = 0;
        else if (m_run[b] == DEB - 1) begin
          m_stable[b] = synced[b]; m_run[b] = 0; nf[b] = !synced[b];
        end else m_run[b]++;
      end
      m_fall = nf;
      void'(dq.pop_front());
      dq.push_back({btn_rev_n, btn_fwd_n});
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R1 R2 R3 phase vs model", phase, m_phase);
      chk("R5 led_red vs model", led_red, m_pend > 0);
      chk("R4 R5 led_green vs model", led_green, m_pend == 0);
      chk("R5 led_blue vs model", led_blue, m_pend < 0);
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && !led_green; i++) @(negedge clk);
  endtask

  initial begin
    int gap;
    logic [3:0] prev;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 phase at reset", phase, 0);
    chk("R11 green at reset", led_green, 1);
    chk("R11 red/blue at reset", {led_red, led_blue}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: short glitch ignored
    btn_fwd_n = 1'b0;
    repeat (DEB - 50) @(negedge clk);
    btn_fwd_n = 1'b1;
    repeat (200) @(negedge clk);
    chk("R9 glitch leaves idle", led_green, 1);
    chk("R9 glitch leaves phase", phase, 0);

    // R8 R9: forward press timing
    btn_fwd_n = 1'b0;
    repeat (DEB + 2) @(negedge clk);
    chk("R9 not yet accepted", led_red, 0);
    @(negedge clk);
    chk("R9 accepted on edge DEB+3", led_red, 1);
    // R6: step spacing
    prev = phase;
    while (phase == prev) @(negedge clk);
    prev = phase; gap = 0;
    while (phase == prev) begin @(negedge clk); gap++; end
    chk("R6 cycles between steps", gap, P);
    repeat (40) @(negedge clk);
    btn_fwd_n = 1'b1;                      // R8 release during motion
    repeat (20) @(negedge clk);
    btn_rev_n = 1'b0;                      // R8 press during motion
    repeat (DEB + 40) @(negedge clk);
    btn_rev_n = 1'b1;
    chk("R8 press while moving ignored", led_red, 1);
    wait_idle(25000);
    chk("R7 forward half turn ends idle", led_green, 1);
    chk("R7 forward end phase index 6", phase, 4'b1000);

    // R4: idle hold
    repeat (100) @(negedge clk);
    chk("R4 phase held while idle", phase, 4'b1000);

    // R3 R7: backward move
    btn_rev_n = 1'b0;
    repeat (DEB + 3) @(negedge clk);
    chk("R5 blue while reversing", led_blue, 1);
    chk("R5 red off while reversing", led_red, 0);
    btn_rev_n = 1'b1;
    wait_idle(25000);
    chk("R3 backward half turn ends idle", led_green, 1);
    chk("R3 R7 backward end phase index 0", phase, 4'b0001);

    // R10: simultaneous presses
    repeat (20) @(negedge clk);
    btn_fwd_n = 1'b0; btn_rev_n = 1'b0;
    repeat (DEB + 3) @(negedge clk);
    chk("R10 forward wins", led_red, 1);
    chk("R10 backward dropped", led_blue, 0);
    btn_fwd_n = 1'b1; btn_rev_n = 1'b1;
    wait_idle(25000);
    chk("R10 move ends at index 6", phase, 4'b1000);
    repeat (10) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule